// File: doc/BRIEF.md
# Display Timing Generator with Shadowed Timing Registers

This block produces the raster timing for a pixel output interface: a horizontal sync, a vertical sync, a data-enable that marks visible pixels, and a one-cycle frame-end pulse. One pixel is produced per clock. Every line runs through four regions in a fixed order (visible pixels, front porch, sync pulse, back porch), and every frame runs through the same four regions counted in lines.

Software programs the timing through a simple word write port. Each timing register has a pending copy, which takes the write, and an active copy, which drives the counters. Pending values move into the active copies only on the last pixel of a whole frame while the engine runs, so a frame is never drawn with a mix of old and new settings. Each register (a "unit") has a reload-block bit that keeps its active copy frozen at those boundaries. A frame-end status flag, masked by an enable bit and cleared by writing a one, drives the interrupt output.

Register word addresses: 0 horizontal porches, 1 horizontal sync width, 2 vertical porches, 3 vertical sync width, 4 visible size, 5 sync polarity, 6 control, 7 interrupt clear, 8 and up reload-block words.

Top module: `disp_timing_gen`

## Requirements
- R1: A line is `W + HFP + HSW + HBP` clocks long; pixels 0..W-1 are visible, then HFP front-porch pixels, then HSW sync pixels, then HBP back-porch pixels; `de_o` is high only on visible pixels of visible lines.
- R2: A frame is `H + VFP + VSW + VBP` lines long with the same order in lines; the vertical sync is active on every pixel of lines H+VFP up to H+VFP+VSW-1.
- R3: Sizes and sync widths are written as the true value minus one: address 4 holds H-1 in bits [27:16] and W-1 in bits [11:0]; address 1 holds HSW-1 and address 3 holds VSW-1 in bits [11:0]; addresses 0 and 2 hold the back porch in bits [27:16] and the front porch, as a true count that may be zero, in bits [11:0].
- R4: The vertical sync pulse lasts at most 15 lines; a larger programmed width yields exactly 15.
- R5: Address 5 bit 0 makes the horizontal sync active-low and bit 1 makes the vertical sync active-low; while stopped both syncs sit at their inactive level.
- R6: Written timing values take effect only at the end of the last pixel of a full frame while the engine runs (address 6 bit 0); a write made while stopped first shows in the frame after the one that follows a restart, and a restart begins at pixel 0 of line 0.
- R7: Reload-block bits use a flat unit index (0 horizontal porches, 1 horizontal sync, 2 vertical porches, 3 vertical sync, 4 size, 5 polarity): word address 8 + index/32, bit index%32; a set bit keeps that unit's active value unchanged at frame boundaries.
- R8: `frame_end_o` pulses for one clock on the last visible pixel of the last visible line.
- R9: A frame-end pulse sets a status flag on the next clock; writing a word with bit 0 set to address 7 clears it, a zero there has no effect; `irq_o` is the flag gated by address 6 bit 1.
- R10: After reset the engine is stopped, the interrupt is disabled and clear, and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Register word address |
| wr_data_i | input | DATA_W | Register write data |
| hsync_o | output | 1 | Horizontal sync, polarity applied |
| vsync_o | output | 1 | Vertical sync, polarity applied |
| de_o | output | 1 | Visible-pixel data enable |
| frame_end_o | output | 1 | Pulse on last visible pixel of frame |
| irq_o | output | 1 | Masked frame-end interrupt |

## Verification
The raster is compared pixel by pixel over several consecutive frames: a small default raster with one-pixel porches, then a reprogrammed raster with a zero front porch, a two-pixel sync and an oversized vertical sync that must clip to 15 lines, then the same raster with both polarities inverted. The changes are written mid-frame, so an early commit shows up as a wrong line length within the frame where it was written. The polarity change is first held back by its reload-block bit and released one frame later, which separates the per-unit block from the frame-boundary commit. A stop, interrupt mask, clear and restart sequence checks the flag handling and that a value written while stopped waits for a frame boundary.

// File: rtl/dtg_pkg.sv
package dtg_pkg;
   // unit indices, also the reload-block flat index
   localparam int UNIT_HPORCH = 0;
   localparam int UNIT_HSYNC  = 1;
   localparam int UNIT_VPORCH = 2;
   localparam int UNIT_VSYNC  = 3;
   localparam int UNIT_SIZE   = 4;
   localparam int UNIT_POL    = 5;
   localparam int NUM_UNITS   = 6;

   // non-shadowed registers
   localparam int REG_CTRL     = 6;
   localparam int REG_IRQ_CLR  = 7;
   localparam int REG_RLD_BASE = 8;

   localparam int CTRL_RUN_BIT    = 0;
   localparam int CTRL_IRQ_EN_BIT = 1;
   localparam int UPPER_LSB       = 16;
endpackage

// File: rtl/dtg_regs.sv
module dtg_regs
   import dtg_pkg::*;
#(
   parameter int ADDR_W = 4,
   parameter int DATA_W = 32,
   parameter logic [NUM_UNITS-1:0][DATA_W-1:0] RESET_WORDS = '0
) (
   input  logic                              clk_i,
   input  logic                              rst_ni,
   input  logic                              wr_en_i,
   input  logic [ADDR_W-1:0]                 wr_addr_i,
   input  logic [DATA_W-1:0]                 wr_data_i,
   input  logic                              commit_i,
   output logic [NUM_UNITS-1:0][DATA_W-1:0]  act_o,
   output logic [NUM_UNITS-1:0]              rld_dis_o,
   output logic                              run_o,
   output logic                              irq_en_o,
   output logic                              clr_o
);
   logic [NUM_UNITS-1:0][DATA_W-1:0] pend_q;

   for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
      localparam int RLD_WORD = REG_RLD_BASE + u / 32;
      localparam int RLD_BIT  = u % 32;

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            pend_q[u] <= RESET_WORDS[u];
            act_o[u]  <= RESET_WORDS[u];
         end else begin
            if (wr_en_i && wr_addr_i == ADDR_W'(u))
               pend_q[u] <= wr_data_i;
            if (commit_i && !rld_dis_o[u])
               act_o[u] <= pend_q[u];
         end
      end

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)
            rld_dis_o[u] <= 1'b0;
         else if (wr_en_i && wr_addr_i == ADDR_W'(RLD_WORD))
            rld_dis_o[u] <= wr_data_i[RLD_BIT];
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         run_o    <= 1'b0;
         irq_en_o <= 1'b0;
      end else if (wr_en_i && wr_addr_i == ADDR_W'(REG_CTRL)) begin
         run_o    <= wr_data_i[CTRL_RUN_BIT];
         irq_en_o <= wr_data_i[CTRL_IRQ_EN_BIT];
      end
   end

   assign clr_o = wr_en_i && (wr_addr_i == ADDR_W'(REG_IRQ_CLR)) && wr_data_i[0];
endmodule

// File: rtl/dtg_counters.sv
module dtg_counters #(
   parameter int TOT_W = 14
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             run_i,
   input  logic [TOT_W-1:0] h_act_i,
   input  logic [TOT_W-1:0] h_fp_i,
   input  logic [TOT_W-1:0] h_sw_i,
   input  logic [TOT_W-1:0] h_bp_i,
   input  logic [TOT_W-1:0] v_act_i,
   input  logic [TOT_W-1:0] v_fp_i,
   input  logic [TOT_W-1:0] v_sw_i,
   input  logic [TOT_W-1:0] v_bp_i,
   output logic             hs_act_o,
   output logic             vs_act_o,
   output logic             de_o,
   output logic             fe_o,
   output logic             commit_o
);
   logic [TOT_W-1:0] h_q, v_q;
   logic [TOT_W-1:0] h_sync_beg, h_sync_end, h_total;
   logic [TOT_W-1:0] v_sync_beg, v_sync_end, v_total;
   logic             h_last, v_last;

   assign h_sync_beg = h_act_i + h_fp_i;
   assign h_sync_end = h_sync_beg + h_sw_i;
   assign h_total    = h_sync_end + h_bp_i;
   assign v_sync_beg = v_act_i + v_fp_i;
   assign v_sync_end = v_sync_beg + v_sw_i;
   assign v_total    = v_sync_end + v_bp_i;

   assign h_last = (h_q == h_total - TOT_W'(1));
   assign v_last = (v_q == v_total - TOT_W'(1));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         h_q <= '0;
         v_q <= '0;
      end else if (!run_i) begin
         h_q <= '0;
         v_q <= '0;
      end else if (h_last) begin
         h_q <= '0;
         v_q <= v_last ? '0 : v_q + TOT_W'(1);
      end else begin
         h_q <= h_q + TOT_W'(1);
      end
   end

   assign hs_act_o = run_i && (h_q >= h_sync_beg) && (h_q < h_sync_end);
   assign vs_act_o = run_i && (v_q >= v_sync_beg) && (v_q < v_sync_end);
   assign de_o     = run_i && (h_q < h_act_i) && (v_q < v_act_i);
   assign fe_o     = run_i && (h_q == h_act_i - TOT_W'(1)) && (v_q == v_act_i - TOT_W'(1));
   assign commit_o = run_i && h_last && v_last;
endmodule

// File: rtl/dtg_irq.sv
module dtg_irq (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic fe_i,
   input  logic clr_i,
   input  logic irq_en_i,
   output logic status_o,
   output logic irq_o
);
   // a new frame end wins over a clear in the same cycle
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
         status_o <= 1'b0;
      else if (fe_i)
         status_o <= 1'b1;
      else if (clr_i)
         status_o <= 1'b0;
   end

   assign irq_o = status_o && irq_en_i;
endmodule

// File: rtl/disp_timing_gen.sv
module disp_timing_gen
   import dtg_pkg::*;
#(
   parameter int ADDR_W    = 4,
   parameter int DATA_W    = 32,
   parameter int CNT_W     = 12,
   parameter int VSYNC_MAX = 15,
   parameter int H_ACTIVE  = 4,
   parameter int H_FP      = 1,
   parameter int H_SYNC    = 1,
   parameter int H_BP      = 1,
   parameter int V_ACTIVE  = 3,
   parameter int V_FP      = 1,
   parameter int V_SYNC    = 1,
   parameter int V_BP      = 1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  logic [DATA_W-1:0] wr_data_i,
   output logic              hsync_o,
   output logic              vsync_o,
   output logic              de_o,
   output logic              frame_end_o,
   output logic              irq_o
);
   localparam int TOT_W     = CNT_W + 2;
   localparam int RLD_WORDS = (NUM_UNITS + 31) / 32;
   localparam logic [NUM_UNITS-1:0][DATA_W-1:0] RESET_WORDS = {
      DATA_W'(0),
      DATA_W'(((V_ACTIVE - 1) << UPPER_LSB) | (H_ACTIVE - 1)),
      DATA_W'(V_SYNC - 1),
      DATA_W'((V_BP << UPPER_LSB) | V_FP),
      DATA_W'(H_SYNC - 1),
      DATA_W'((H_BP << UPPER_LSB) | H_FP)
   };

   if (CNT_W < 4 || CNT_W > UPPER_LSB) begin : g_bad_cnt
      $error("CNT_W must lie in 4..16");
   end
   if (DATA_W < UPPER_LSB + CNT_W) begin : g_bad_data
      $error("DATA_W too narrow for the packed fields");
   end
   if (REG_RLD_BASE + RLD_WORDS > (1 << ADDR_W)) begin : g_bad_addr
      $error("ADDR_W too narrow for the reload-block words");
   end
   if (VSYNC_MAX < 1 || VSYNC_MAX >= (1 << CNT_W)) begin : g_bad_vmax
      $error("VSYNC_MAX out of range");
   end

   logic [NUM_UNITS-1:0][DATA_W-1:0] act_words;
   logic [NUM_UNITS-1:0]             rld_dis;
   logic run, irq_en, irq_clr, irq_status;
   logic commit, hs_act, vs_act;
   logic unused_words;

   logic [TOT_W-1:0] h_act, h_fp, h_sw, h_bp;
   logic [TOT_W-1:0] v_act, v_fp, v_sw, v_bp, v_sw_full;

   dtg_regs #(
      .ADDR_W      (ADDR_W),
      .DATA_W      (DATA_W),
      .RESET_WORDS (RESET_WORDS)
   ) u_regs (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_en_i   (wr_en_i),
      .wr_addr_i (wr_addr_i),
      .wr_data_i (wr_data_i),
      .commit_i  (commit),
      .act_o     (act_words),
      .rld_dis_o (rld_dis),
      .run_o     (run),
      .irq_en_o  (irq_en),
      .clr_o     (irq_clr)
   );

   // field decode of the active copies
   assign h_fp  = TOT_W'(act_words[UNIT_HPORCH][CNT_W-1:0]);
   assign h_bp  = TOT_W'(act_words[UNIT_HPORCH][UPPER_LSB +: CNT_W]);
   assign h_sw  = TOT_W'(act_words[UNIT_HSYNC][CNT_W-1:0]) + TOT_W'(1);
   assign h_act = TOT_W'(act_words[UNIT_SIZE][CNT_W-1:0]) + TOT_W'(1);
   assign v_fp  = TOT_W'(act_words[UNIT_VPORCH][CNT_W-1:0]);
   assign v_bp  = TOT_W'(act_words[UNIT_VPORCH][UPPER_LSB +: CNT_W]);
   assign v_act = TOT_W'(act_words[UNIT_SIZE][UPPER_LSB +: CNT_W]) + TOT_W'(1);
   assign v_sw_full = TOT_W'(act_words[UNIT_VSYNC][CNT_W-1:0]) + TOT_W'(1);
   assign v_sw  = (v_sw_full > TOT_W'(VSYNC_MAX)) ? TOT_W'(VSYNC_MAX) : v_sw_full;
   assign unused_words = ^act_words;

   dtg_counters #(.TOT_W(TOT_W)) u_cnt (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .run_i    (run),
      .h_act_i  (h_act),
      .h_fp_i   (h_fp),
      .h_sw_i   (h_sw),
      .h_bp_i   (h_bp),
      .v_act_i  (v_act),
      .v_fp_i   (v_fp),
      .v_sw_i   (v_sw),
      .v_bp_i   (v_bp),
      .hs_act_o (hs_act),
      .vs_act_o (vs_act),
      .de_o     (de_o),
      .fe_o     (frame_end_o),
      .commit_o (commit)
   );

   dtg_irq u_irq (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .fe_i     (frame_end_o),
      .clr_i    (irq_clr),
      .irq_en_i (irq_en),
      .status_o (irq_status),
      .irq_o    (irq_o)
   );

   assign hsync_o = hs_act ^ act_words[UNIT_POL][0];
   assign vsync_o = vs_act ^ act_words[UNIT_POL][1];
endmodule

// File: rtl/disp_timing_gen_chk.sv
module disp_timing_gen_chk
   import dtg_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input logic                             clk_i,
   input logic                             rst_ni,
   input logic                             run_i,
   input logic                             de_i,
   input logic                             fe_i,
   input logic                             hs_act_i,
   input logic                             vs_act_i,
   input logic                             status_i,
   input logic                             irq_i,
   input logic                             irq_en_i,
   input logic                             commit_i,
   input logic [NUM_UNITS-1:0]             rld_dis_i,
   input logic [NUM_UNITS-1:0][DATA_W-1:0] act_i
);
   AST_DE_OUTSIDE_SYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
      de_i |-> !hs_act_i && !vs_act_i); // R1
   AST_FE_ON_VISIBLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fe_i |-> de_i); // R8
   AST_STATUS_AFTER_FE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fe_i |=> status_i); // R9
   AST_IRQ_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_i |-> irq_en_i && status_i); // R9
   AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !run_i |-> !de_i && !fe_i && !hs_act_i && !vs_act_i); // R5
   AST_SHADOW_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !commit_i |=> $stable(act_i)); // R6

   for (genvar u = 0; u < NUM_UNITS; u++) begin : g_rld
      AST_RLD_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
         rld_dis_i[u] |=> $stable(act_i[u])); // R7
   end
endmodule

bind disp_timing_gen disp_timing_gen_chk u_chk (
   .clk_i     (clk_i),
   .rst_ni    (rst_ni),
   .run_i     (run),
   .de_i      (de_o),
   .fe_i      (frame_end_o),
   .hs_act_i  (hs_act),
   .vs_act_i  (vs_act),
   .status_i  (irq_status),
   .irq_i     (irq_o),
   .irq_en_i  (irq_en),
   .commit_i  (commit),
   .rld_dis_i (rld_dis),
   .act_i     (act_words)
);

// File: tb/disp_timing_gen_test.sv
module disp_timing_gen_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic        hsync, vsync, de, fe, irq;

   int n_checks = 0;
   int n_fail   = 0;
   bit mon_go   = 1'b0;

   typedef struct {
      logic  hs;
      logic  vs;
      logic  de;
      logic  fe;
      string tag;
   } exp_t;
   exp_t exp_q[$];

   always #2 clk = ~clk;

   disp_timing_gen uut (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .wr_en_i     (wr_en),
      .wr_addr_i   (wr_addr),
      .wr_data_i   (wr_data),
      .hsync_o     (hsync),
      .vsync_o     (vsync),
      .de_o        (de),
      .frame_end_o (fe),
      .irq_o       (irq)
   );

   task automatic chk(input string req, input string what, input logic act, input logic exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic wr(input int addr, input int data);
      wr_addr = 4'(addr);
      wr_data = 32'(data);
      wr_en   = 1'b1;
      @(negedge clk);
      wr_en   = 1'b0;
   endtask

   // driver: expected raster of one frame, from the requirement wording
   task automatic push_frame(input int w, input int h, input int hfp, input int hsw,
                             input int hbp, input int vfp, input int vsw, input int vbp,
                             input logic ph, input logic pv, input string tag);
      for (int y = 0; y < h + vfp + vsw + vbp; y++) begin
         for (int x = 0; x < w + hfp + hsw + hbp; x++) begin
            exp_t e;
            e.de  = (x < w) && (y < h);
            e.hs  = ((x >= w + hfp) && (x < w + hfp + hsw)) ^ ph;
            e.vs  = ((y >= h + vfp) && (y < h + vfp + vsw)) ^ pv;
            e.fe  = (x == w - 1) && (y == h - 1);
            e.tag = tag;
            exp_q.push_back(e);
         end
      end
   endtask

   // monitor: one expected item per pixel clock
   always begin
      @(negedge clk);
      #1;
      if (mon_go && exp_q.size() > 0) begin
         exp_t e;
         e = exp_q.pop_front();
         chk(e.tag, "hsync", hsync, e.hs);
         chk(e.tag, "vsync", vsync, e.vs);
         chk(e.tag, "de", de, e.de);
         chk(e.tag, "frame_end", fe, e.fe);
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog R6: actual hung, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 reset state
      chk("R10", "de", de, 1'b0);
      chk("R10", "hsync", hsync, 1'b0);
      chk("R10", "vsync", vsync, 1'b0);
      chk("R10", "frame_end", fe, 1'b0);
      chk("R10", "irq", irq, 1'b0);

      // default raster, then reprogrammed, then polarity released
      push_frame(4, 3, 1, 1, 1, 1, 1, 1, 1'b0, 1'b0, "R1 R2 R8");
      push_frame(3, 2, 0, 2, 2, 2, 15, 0, 1'b0, 1'b0, "R3 R4 R6 R7");
      push_frame(3, 2, 0, 2, 2, 2, 15, 0, 1'b1, 1'b1, "R5 R7");
      wr(6, 1);
      mon_go = 1'b1;
      repeat (2) @(negedge clk);
      wr(8, 32'h20);                      // block unit 5 (polarity)
      wr(5, 3);
      wr(0, (2 << 16) | 0);
      wr(1, 1);
      wr(2, (0 << 16) | 2);
      wr(3, 19);                          // capped to 15 lines
      wr(4, (1 << 16) | 2);
      repeat (60) @(negedge clk);         // inside the second frame
      wr(8, 0);
      wait (exp_q.size() == 0);
      @(negedge clk);

      // stop: idle levels with inverted polarity, interrupt masked
      wr(6, 0);
      chk("R5", "idle hsync", hsync, 1'b1);
      chk("R5", "idle vsync", vsync, 1'b1);
      chk("R6", "idle de", de, 1'b0);
      chk("R9", "masked irq", irq, 1'b0);
      wr(6, 2);
      chk("R9", "unmasked irq", irq, 1'b1);
      wr(7, 0);
      chk("R9", "irq after zero clear", irq, 1'b1);
      wr(7, 1);
      chk("R9", "irq after clear", irq, 1'b0);

      // write while stopped waits for a frame boundary after restart
      wr(4, 0);
      mon_go = 1'b0;
      push_frame(3, 2, 0, 2, 2, 2, 15, 0, 1'b1, 1'b1, "R6");
      wr(6, 3);
      mon_go = 1'b1;
      wait (exp_q.size() == 0);
      @(negedge clk);
      chk("R9", "irq after restart frame", irq, 1'b1);

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule